// File: doc/BRIEF.md
# Bit-Sliced Ripple ALU

This block is a 32-bit integer arithmetic and logic unit. It is built by structure rather than by behaviour: a chain of identical one-bit slices, each made of gate-level AND, OR and inverters, a full adder and a four-way output selector. A carry ripples from the least significant slice to the most significant one. Subtraction and NOR come from two operand-invert controls. Set-less-than takes a sign bit from the top slice and feeds it back into the bottom slice.

A 4-bit control word picks the operation, and the control is decoded as independent fields. Bit 3 inverts operand A. Bit 2 inverts operand B and also drives the carry into slice 0. Bits 1:0 select the slice output: 00 AND, 01 OR, 10 adder sum, 11 the less input. The result, zero flag, carry-out and overflow are captured in output registers on every clock edge. Each result therefore appears one cycle after its operands and control. The reset is asynchronous and active-low, and it is assumed to be released in step with the clock.

Top module: `bsalu_top`

## Requirements
- R1: While reset is low, result, carry_out and overflow read 0 and zero reads 1. After reset is released, each output shows the value computed from the inputs sampled at the previous rising clock edge.
- R2: Control 0000 yields the bitwise AND of A and B.
- R3: Control 0001 yields the bitwise OR of A and B.
- R4: Control 0010 yields A+B modulo 2^32. carry_out is the unsigned carry out of bit 31.
- R5: Control 0110 yields A-B modulo 2^32. carry_out is 1 exactly when A >= B as unsigned numbers, meaning no borrow.
- R6: Control 0111 yields 1 in bit 0 and 0 in all other bits when A < B as signed two's-complement numbers, and 0 otherwise. This holds even when A-B overflows.
- R7: Control 1100 yields the bitwise NOR of A and B.
- R8: zero is 1 exactly when all 32 result bits are 0, for every control value.
- R9: overflow is 1 for add when both operands have the same sign and the sum's sign differs. For subtract it is 1 when the operands differ in sign and the difference's sign differs from A.
- R10: The control is decoded field by field, so codes not listed above still have a defined meaning. For example, 1101 yields NOT A OR NOT B, which is NAND, and 1000 yields NOT A AND B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opnd_a | input | 32 | Operand A |
| opnd_b | input | 32 | Operand B |
| op_ctl | input | 4 | Control: [3] invert A, [2] invert B with carry-in, [1:0] output select |
| result | output | 32 | Registered result |
| zero | output | 1 | Registered all-zero flag |
| carry_out | output | 1 | Registered carry out of the top slice |
| overflow | output | 1 | Registered signed overflow of the top slice |

## Verification
A broken slice or a broken carry link shows up at the ports one cycle after the operands that reach it. It appears in the result bit at that position, or in every bit above it when the fault is in the carry. The operand patterns are chosen so that carries run the full length of the chain. A fault in the set-less-than feedback or in the top slice's overflow shows up only for signed comparisons near the sign boundary, so those pairs are applied on purpose. The zero flag is checked on results from both the logic and the arithmetic paths.

// File: rtl/bsalu_pkg.sv
package bsalu_pkg;
  localparam int unsigned CTL_W = 4;

  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_LESS = 2'b11
  } out_sel_e;

  typedef struct packed {
    logic     inv_a;
    logic     inv_b;
    out_sel_e sel;
  } alu_ctl_t;

  localparam logic [CTL_W-1:0] OP_AND = 4'b0000;
  localparam logic [CTL_W-1:0] OP_OR  = 4'b0001;
  localparam logic [CTL_W-1:0] OP_ADD = 4'b0010;
  localparam logic [CTL_W-1:0] OP_SUB = 4'b0110;
  localparam logic [CTL_W-1:0] OP_SLT = 4'b0111;
  localparam logic [CTL_W-1:0] OP_NOR = 4'b1100;
endpackage

// File: rtl/bsalu_slice.sv
module bsalu_slice
  import bsalu_pkg::*;
(
  input  logic     a_i,
  input  logic     b_i,
  input  logic     inv_a,
  input  logic     inv_b,
  input  out_sel_e sel,
  input  logic     less_i,
  input  logic     cin,
  output logic     res_o,
  output logic     cout
);
  logic a_m, b_m, and_w, or_w, sum_w;

  assign a_m   = inv_a ? ~a_i : a_i;
  assign b_m   = inv_b ? ~b_i : b_i;
  assign and_w = a_m & b_m;
  assign or_w  = a_m | b_m;
  assign sum_w = a_m ^ b_m ^ cin;
  assign cout  = (a_m & b_m) | (a_m & cin) | (b_m & cin);

  always_comb begin
    unique case (sel)
      SEL_AND: res_o = and_w;
      SEL_OR:  res_o = or_w;
      SEL_SUM: res_o = sum_w;
      default: res_o = less_i;
    endcase
  end
endmodule

// File: rtl/bsalu_msb_slice.sv
module bsalu_msb_slice
  import bsalu_pkg::*;
(
  input  logic     a_i,
  input  logic     b_i,
  input  logic     inv_a,
  input  logic     inv_b,
  input  out_sel_e sel,
  input  logic     less_i,
  input  logic     cin,
  output logic     res_o,
  output logic     cout,
  output logic     set_o,
  output logic     ovf_o
);
  logic a_m, b_m, sum_w;

  assign a_m   = inv_a ? ~a_i : a_i;
  assign b_m   = inv_b ? ~b_i : b_i;
  assign sum_w = a_m ^ b_m ^ cin;
  assign cout  = (a_m & b_m) | (a_m & cin) | (b_m & cin);
  // Signed overflow: carry entering the sign bit differs from carry leaving it
  assign ovf_o = cin ^ cout;
  // True sign of A-B even when the difference overflows
  assign set_o = sum_w ^ ovf_o;

  always_comb begin
    unique case (sel)
      SEL_AND: res_o = a_m & b_m;
      SEL_OR:  res_o = a_m | b_m;
      SEL_SUM: res_o = sum_w;
      default: res_o = less_i;
    endcase
  end
endmodule

// File: rtl/bsalu_chain.sv
module bsalu_chain
  import bsalu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  alu_ctl_t         ctl,
  output logic [WIDTH-1:0] res_o,
  output logic             cout_o,
  output logic             ovf_o
);
  localparam int unsigned TOP = WIDTH - 1;

  logic set_w;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic ci, co, less_w, rb;

    if (i == 0) begin : g_first
      assign ci     = ctl.inv_b;
      assign less_w = set_w;
    end else begin : g_rest
      assign ci     = g_bit[i-1].co;
      assign less_w = 1'b0;
    end

    if (i == TOP) begin : g_msb
      bsalu_msb_slice u_slice (
        .a_i(a_i[i]), .b_i(b_i[i]), .inv_a(ctl.inv_a), .inv_b(ctl.inv_b),
        .sel(ctl.sel), .less_i(less_w), .cin(ci), .res_o(rb), .cout(co),
        .set_o(set_w), .ovf_o(ovf_o)
      );
    end else begin : g_lsb
      bsalu_slice u_slice (
        .a_i(a_i[i]), .b_i(b_i[i]), .inv_a(ctl.inv_a), .inv_b(ctl.inv_b),
        .sel(ctl.sel), .less_i(less_w), .cin(ci), .res_o(rb), .cout(co)
      );
    end

    assign res_o[i] = rb;
  end

  assign cout_o = g_bit[TOP].co;
endmodule

// File: rtl/bsalu_top.sv
module bsalu_top
  import bsalu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [CTL_W-1:0] op_ctl,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             carry_out,
  output logic             overflow
);
  alu_ctl_t         ctl_w;
  logic [WIDTH-1:0] res_nxt;
  logic             zero_nxt, cout_nxt, ovf_nxt;
  logic             cap_en;

  assign ctl_w  = alu_ctl_t'(op_ctl);
  assign cap_en = 1'b1;

  bsalu_chain #(.WIDTH(WIDTH)) u_chain (
    .a_i(opnd_a), .b_i(opnd_b), .ctl(ctl_w),
    .res_o(res_nxt), .cout_o(cout_nxt), .ovf_o(ovf_nxt)
  );

  assign zero_nxt = ~(|res_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result    <= '0;
      zero      <= 1'b1;
      carry_out <= 1'b0;
      overflow  <= 1'b0;
    end else if (cap_en) begin
      result    <= res_nxt;
      zero      <= zero_nxt;
      carry_out <= cout_nxt;
      overflow  <= ovf_nxt;
    end
  end

  // R2
  a_r2_and: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(op_ctl) == OP_AND |-> result == ($past(opnd_a) & $past(opnd_b)));
  // R4
  a_r4_add: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(op_ctl) == OP_ADD
    |-> {carry_out, result} == ({1'b0, $past(opnd_a)} + {1'b0, $past(opnd_b)}));
  // R5
  a_r5_sub: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(op_ctl) == OP_SUB
    |-> result == $past(opnd_a) - $past(opnd_b) && carry_out == ($past(opnd_a) >= $past(opnd_b)));
  // R6
  a_r6_slt: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(op_ctl) == OP_SLT
    |-> result == {{(WIDTH-1){1'b0}}, ($signed($past(opnd_a)) < $signed($past(opnd_b)))});
  // R8
  a_r8_zero: assert property (@(posedge clk) disable iff (!rst_n)
    zero == (result == '0));
  // R9
  a_r9_ovf_add: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(op_ctl) == OP_ADD
    |-> overflow == (($past(opnd_a[WIDTH-1]) == $past(opnd_b[WIDTH-1]))
                     && (result[WIDTH-1] != $past(opnd_a[WIDTH-1]))));
endmodule

// File: tb/bsalu_top_test.sv
module bsalu_top_test;
  localparam int W = 32;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] opnd_a, opnd_b;
  logic [3:0]   op_ctl;
  logic [W-1:0] result;
  logic         zero, carry_out, overflow;

  int n_chk;
  int n_fail;

  bsalu_top uut (
    .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b), .op_ctl(op_ctl),
    .result(result), .zero(zero), .carry_out(carry_out), .overflow(overflow)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [W+2:0] act, input logic [W+2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Reference from the field-decoded control meaning (R10)
  task automatic run(input string req, input logic [W-1:0] a, input logic [W-1:0] b,
                     input logic [3:0] c, input bit chk_flags);
    logic [W-1:0] am, bm, r;
    logic [W:0]   s;
    logic         ov;
    am = c[3] ? ~a : a;
    bm = c[2] ? ~b : b;
    s  = {1'b0, am} + {1'b0, bm} + {{W{1'b0}}, c[2]};
    ov = (am[W-1] == bm[W-1]) && (s[W-1] != am[W-1]);
    case (c[1:0])
      2'b00:   r = am & bm;
      2'b01:   r = am | bm;
      2'b10:   r = s[W-1:0];
      default: r = {{(W-1){1'b0}}, s[W-1] ^ ov};
    endcase
    @(negedge clk);
    opnd_a = a; opnd_b = b; op_ctl = c;
    @(negedge clk);
    check(req, {3'b000, result}, {3'b000, r});
    check("R8", {{(W+2){1'b0}}, zero}, {{(W+2){1'b0}}, (r == '0)});
    if (chk_flags) begin
      check(req, {{(W+2){1'b0}}, carry_out}, {{(W+2){1'b0}}, s[W]});
      check("R9", {{(W+2){1'b0}}, overflow}, {{(W+2){1'b0}}, ov});
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    opnd_a = 32'hFFFF_FFFF; opnd_b = 32'h1; op_ctl = 4'b0010;
    repeat (3) @(negedge clk);
    check("R1", {3'b000, result}, '0);
    check("R1", {carry_out, overflow, zero}, 3'b001);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {3'b000, result}, '0);
    check("R1", {{(W+2){1'b0}}, carry_out}, 1);
  endtask

  task automatic t_logic();
    run("R2", 32'hF0F0_1234, 32'hFF00_0F0F, 4'b0000, 0);
    run("R2", 32'hAAAA_AAAA, 32'h5555_5555, 4'b0000, 0);
    run("R3", 32'hF0F0_1234, 32'h0F00_0001, 4'b0001, 0);
    run("R3", 32'h0, 32'h0, 4'b0001, 0);
    run("R7", 32'hF0F0_1234, 32'h0F00_0001, 4'b1100, 0);
    run("R7", 32'hFFFF_0000, 32'h0000_FFFF, 4'b1100, 0);
  endtask

  task automatic t_arith();
    run("R4", 32'h0000_0005, 32'h0000_0007, 4'b0010, 1);
    run("R4", 32'hFFFF_FFFF, 32'h0000_0001, 4'b0010, 1);
    run("R4", 32'h7FFF_FFFF, 32'h0000_0001, 4'b0010, 1);
    run("R4", 32'h8000_0000, 32'h8000_0000, 4'b0010, 1);
    run("R5", 32'h0000_0009, 32'h0000_0009, 4'b0110, 1);
    run("R5", 32'h0000_0003, 32'h0000_0004, 4'b0110, 1);
    run("R5", 32'h8000_0000, 32'h0000_0001, 4'b0110, 1);
    run("R5", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'b0110, 1);
  endtask

  task automatic t_slt();
    run("R6", 32'h0000_0003, 32'h0000_0004, 4'b0111, 0);
    run("R6", 32'h0000_0004, 32'h0000_0003, 4'b0111, 0);
    run("R6", 32'hFFFF_FFFF, 32'h0000_0001, 4'b0111, 0);
    run("R6", 32'h8000_0000, 32'h7FFF_FFFF, 4'b0111, 0);
    run("R6", 32'h7FFF_FFFF, 32'h8000_0000, 4'b0111, 0);
    run("R6", 32'h1234_5678, 32'h1234_5678, 4'b0111, 0);
  endtask

  task automatic t_fields();
    run("R10", 32'hF0F0_00FF, 32'hFF00_0F0F, 4'b1101, 0);
    run("R10", 32'hF0F0_00FF, 32'hFF00_0F0F, 4'b1000, 0);
    run("R10", 32'h0000_0010, 32'h0000_0003, 4'b1010, 0);
  endtask

  initial begin
    n_chk = 0; n_fail = 0;
    t_reset();
    t_logic();
    t_arith();
    t_slt();
    t_fields();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule